// File: doc/BRIEF.md
# Parallel-Bit Execute Packet Splitter

This block takes in a wide fetch packet of eight 32-bit instruction words and hands it out as a sequence of execute packets. Every word carries a chaining flag in its least significant bit. A flag of 1 binds the word to the next word in the same issue cycle. A flag of 0 closes the current group. One execute packet leaves the block per cycle, so a fetch packet takes anywhere from one cycle (all words chained) to eight cycles (no words chained).

Fetch packets arrive on a valid/ready handshake. Execute packets leave as an eight-lane bus with a per-lane membership mask, a valid flag and an end-of-fetch-packet marker. Downstream can hold an execute packet with a stall input. Each word stays in its original lane. Lanes outside the current group have a cleared mask bit and zeroed data. A new fetch packet is accepted no earlier than the cycle in which the final group of the held one is taken, so two fetch packets can follow each other without a gap cycle.

Top module: `pbit_dispatch`

## Requirements
- R1: After reset, `ep_valid` is 0, `ep_mask` is all zero and `fp_ready` is 1.
- R2: The chaining flag is bit 0 of each 32-bit word. Lane i belongs to word bits [32i+31:32i]. When lane i is in the current group and its flag is 1, lane i+1 is in the same group. Two adjacent lanes share a group only if the lower lane's flag is 1.
- R3: A fetch packet with every flag at 0 issues as eight single-lane groups, lane 0 first.
- R4: A fetch packet with every flag on lanes 0 to 6 at 1 issues as a single eight-lane group with `ep_last` set.
- R5: The flag of lane 7 has no effect. A group never reaches past lane 7, and the next fetch packet always starts a new group at lane 0.
- R6: Words keep their lane position. Lanes outside the current group show mask 0 and data 0. While `ep_valid` is 1 the mask is nonzero, and while `ep_valid` is 0 the mask is zero.
- R7: While `ep_valid` and `ep_stall` are both 1, the mask, data and `ep_last` stay unchanged in the next cycle, and `ep_valid` stays 1.
- R8: `fp_ready` is 0 while a fetch packet is held, except in the cycle where its last group is taken (`ep_last`=1, `ep_stall`=0). In that cycle a new fetch packet may be accepted, and its first group appears in the next cycle.
- R9: Groups of one fetch packet come out in ascending lane order, one per cycle in which `ep_stall` is 0. Each group is a contiguous run of lanes, and together the groups cover all eight lanes exactly once.
- R10: `ep_last` is 1 only on the final group of a fetch packet. A taken group without `ep_last` is followed by another valid group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_valid | input | 1 | Fetch packet offered |
| fp_ready | output | 1 | Fetch packet can be accepted this cycle |
| fp_data | input | 256 | Fetch packet, lane i in bits [32i+31:32i] |
| ep_valid | output | 1 | Execute packet present |
| ep_stall | input | 1 | Downstream holds the current execute packet |
| ep_data | output | 256 | Execute packet words in original lanes, others zero |
| ep_mask | output | 8 | Lanes that belong to the current execute packet |
| ep_last | output | 1 | Current execute packet is the final one of its fetch packet |

## Verification
Several properties are checked on every cycle. These are the chaining rule between neighbouring lanes, the contiguity of each mask, the agreement of mask and valid, the hold under stall, the input hold-off while a packet is held, and the rule that a group holding lane 7 is the last one. Other behaviours only show up in the bench's directed scenarios. These are the exact sequence of masks for the all-serial, all-parallel and mixed flag patterns, the lane-7 flag being ignored, and the gap-free handover of two fetch packets back to back. The zeroed data of non-member lanes and the reset state are also checked there.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
    parameter int unsigned DEF_LANES    = 8;
    parameter int unsigned DEF_IW       = 32;
    parameter int unsigned DEF_PBIT_POS = 0;
endpackage

// File: rtl/pbd_group_finder.sv
// Finds the lanes of the next execute packet among the lanes still pending.
module pbd_group_finder #(
    parameter int unsigned LANES = pbd_pkg::DEF_LANES
) (
    input  logic [LANES-1:0] pend,
    input  logic [LANES-1:0] chain,
    output logic [LANES-1:0] grp
);
    logic [LANES-1:0] first;

    assign first = pend & (~pend + 1'b1);

    always_comb begin
        logic running;
        running = 1'b0;
        grp     = '0;
        for (int i = 0; i < LANES; i++) begin
            if (first[i]) running = 1'b1;
            if (running && pend[i]) grp[i] = 1'b1;
            if (grp[i] && !chain[i]) running = 1'b0;
        end
    end
endmodule

// File: rtl/pbd_lane_gate.sv
// Passes member lanes through in place and zeroes the rest.
module pbd_lane_gate #(
    parameter int unsigned LANES = pbd_pkg::DEF_LANES,
    parameter int unsigned IW    = pbd_pkg::DEF_IW
) (
    input  logic [LANES*IW-1:0] din,
    input  logic [LANES-1:0]    keep,
    output logic [LANES*IW-1:0] dout
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout[i*IW +: IW] = keep[i] ? din[i*IW +: IW] : '0;
    end
endmodule

// File: rtl/pbit_dispatch.sv
module pbit_dispatch #(
    parameter int unsigned LANES    = pbd_pkg::DEF_LANES,
    parameter int unsigned IW       = pbd_pkg::DEF_IW,
    parameter int unsigned PBIT_POS = pbd_pkg::DEF_PBIT_POS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fp_valid,
    output logic                fp_ready,
    input  logic [LANES*IW-1:0] fp_data,
    output logic                ep_valid,
    input  logic                ep_stall,
    output logic [LANES*IW-1:0] ep_data,
    output logic [LANES-1:0]    ep_mask,
    output logic                ep_last
);
    localparam int unsigned PW = LANES * IW;

    typedef struct packed {
        logic             busy;
        logic [LANES-1:0] pend;
        logic [PW-1:0]    pkt;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0] chain;
    logic [LANES-1:0] grp;
    logic [LANES-1:0] live;
    logic             last_grp;

    for (genvar i = 0; i < LANES; i++) begin : g_chain
        assign chain[i] = st_q.pkt[i*IW + PBIT_POS];
    end

    pbd_group_finder #(.LANES(LANES)) u_find (
        .pend  (st_q.pend),
        .chain (chain),
        .grp   (grp)
    );

    assign live = st_q.busy ? grp : '0;

    pbd_lane_gate #(.LANES(LANES), .IW(IW)) u_gate (
        .din  (st_q.pkt),
        .keep (live),
        .dout (ep_data)
    );

    always_comb begin
        logic fire;
        logic take;
        st_d     = st_q;
        last_grp = st_q.busy && ((st_q.pend & ~grp) == '0);
        fire     = st_q.busy && !ep_stall;
        fp_ready = !st_q.busy || (last_grp && !ep_stall);
        take     = fp_valid && fp_ready;
        if (fire) begin
            st_d.pend = st_q.pend & ~grp;
            if (last_grp) st_d.busy = 1'b0;
        end
        if (take) begin
            st_d.busy = 1'b1;
            st_d.pend = '1;
            st_d.pkt  = fp_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ep_valid = st_q.busy;
    assign ep_mask  = live;
    assign ep_last  = last_grp;
endmodule

// File: rtl/pbd_checker.sv
module pbd_checker #(
    parameter int unsigned LANES    = pbd_pkg::DEF_LANES,
    parameter int unsigned IW       = pbd_pkg::DEF_IW,
    parameter int unsigned PBIT_POS = pbd_pkg::DEF_PBIT_POS
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fp_ready,
    input logic                ep_valid,
    input logic                ep_stall,
    input logic [LANES*IW-1:0] ep_data,
    input logic [LANES-1:0]    ep_mask,
    input logic                ep_last
);
    logic [LANES-1:0] low;
    assign low = ep_mask & (~ep_mask + 1'b1);

    // R2: chaining rule between neighbouring lanes
    for (genvar i = 0; i + 1 < LANES; i++) begin : g_nb
        assert_chain_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (ep_valid && ep_mask[i] && ep_data[i*IW + PBIT_POS]) |-> ep_mask[i+1]);
        assert_chain_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (ep_valid && ep_mask[i] && ep_mask[i+1]) |-> ep_data[i*IW + PBIT_POS]);
    end

    assert_mask_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ep_valid ? (ep_mask != '0) : (ep_mask == '0));

    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_valid && ep_stall) |=> (ep_valid && $stable(ep_mask) && $stable(ep_data) && $stable(ep_last)));

    assert_no_take_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_valid && !(ep_last && !ep_stall)) |-> !fp_ready);

    assert_contig_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ep_valid |-> (((ep_mask + low) & ep_mask) == '0));

    assert_more_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_valid && !ep_stall && !ep_last) |=> ep_valid);

    assert_top_lane_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_valid && ep_mask[LANES-1]) |-> ep_last);
endmodule

bind pbit_dispatch pbd_checker #(.LANES(LANES), .IW(IW), .PBIT_POS(PBIT_POS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fp_ready (fp_ready),
    .ep_valid (ep_valid),
    .ep_stall (ep_stall),
    .ep_data  (ep_data),
    .ep_mask  (ep_mask),
    .ep_last  (ep_last)
);

// File: tb/pbit_dispatch_tb.sv
module pbit_dispatch_tb;
    localparam int L = 8;
    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           fp_valid = 1'b0;
    logic           fp_ready;
    logic [L*W-1:0] fp_data = '0;
    logic           ep_valid;
    logic           ep_stall = 1'b0;
    logic [L*W-1:0] ep_data;
    logic [L-1:0]   ep_mask;
    logic           ep_last;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    pbit_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .fp_valid(fp_valid), .fp_ready(fp_ready),
        .fp_data(fp_data), .ep_valid(ep_valid), .ep_stall(ep_stall),
        .ep_data(ep_data), .ep_mask(ep_mask), .ep_last(ep_last)
    );

    task automatic chk(input bit ok, input string req, input logic [L*W-1:0] act, input logic [L*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [L*W-1:0] mk(input logic [L-1:0] fl, input logic [7:0] seed);
        logic [L*W-1:0] r;
        for (int i = 0; i < L; i++)
            r[i*W +: W] = {seed, 8'(i), 15'(seed * 3 + i * 77), fl[i]};
        return r;
    endfunction

    function automatic logic [L*W-1:0] gate(input logic [L*W-1:0] d, input logic [L-1:0] m);
        logic [L*W-1:0] r;
        for (int i = 0; i < L; i++) r[i*W +: W] = m[i] ? d[i*W +: W] : '0;
        return r;
    endfunction

    // Offers one packet, then checks each group in turn against the expected masks.
    task automatic run_pkt(input logic [L*W-1:0] d, input logic [L-1:0] em [8], input int n, input string req);
        @(negedge clk);
        fp_valid = 1'b1; fp_data = d; ep_stall = 1'b0;
        #1 chk(fp_ready === 1'b1, {req, " ready idle"}, 256'(fp_ready), 256'(1));
        @(posedge clk); @(negedge clk);
        fp_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            #1;
            chk(ep_valid === 1'b1 && ep_mask === em[k], {req, " mask"}, 256'(ep_mask), 256'(em[k]));
            chk(ep_data === gate(d, em[k]), {req, " data R6"}, ep_data, gate(d, em[k]));
            chk(ep_last === (k == n - 1), {req, " last R10"}, 256'(ep_last), 256'(k == n - 1));
            chk(fp_ready === (k == n - 1), {req, " ready R8"}, 256'(fp_ready), 256'(k == n - 1));
            @(posedge clk); @(negedge clk);
        end
        #1 chk(ep_valid === 1'b0 && ep_mask === '0, {req, " drained R9"}, 256'(ep_mask), 256'(0));
    endtask

    task automatic t_reset;
        #1 chk(ep_valid === 1'b0 && ep_mask === '0 && fp_ready === 1'b1, "R1 reset state",
               256'({ep_valid, ep_mask, fp_ready}), 256'(1));
    endtask

    task automatic t_serial;
        logic [L-1:0] em [8];
        for (int i = 0; i < 8; i++) em[i] = 8'(1 << i);
        run_pkt(mk(8'h00, 8'h11), em, 8, "R3 serial");
    endtask

    task automatic t_parallel;
        logic [L-1:0] em [8];
        for (int i = 0; i < 8; i++) em[i] = '0;
        em[0] = 8'hFF;
        run_pkt(mk(8'h7F, 8'h22), em, 1, "R4 parallel");
    endtask

    task automatic t_mixed;
        logic [L-1:0] em [8];
        for (int i = 0; i < 8; i++) em[i] = '0;
        // flags lane0..7 = 1,1,0,0,1,0,1,0 -> {0,1,2} {3} {4,5} {6,7}
        em[0] = 8'h07; em[1] = 8'h08; em[2] = 8'h30; em[3] = 8'hC0;
        run_pkt(mk(8'b0101_0011, 8'h33), em, 4, "R2 mixed");
        // flags 0,1,1,0,0,0,1,1 -> {0} {1,2,3} {4} {5} {6,7}
        em[0] = 8'h01; em[1] = 8'h0E; em[2] = 8'h10; em[3] = 8'h20; em[4] = 8'hC0;
        run_pkt(mk(8'b1100_0110, 8'h44), em, 5, "R9 mixed");
    endtask

    task automatic t_top_flag;
        logic [L-1:0] em [8];
        for (int i = 0; i < 8; i++) em[i] = 8'(1 << i);
        run_pkt(mk(8'h80, 8'h55), em, 8, "R5 lane7 flag");
        for (int i = 0; i < 8; i++) em[i] = '0;
        em[0] = 8'hFF;
        run_pkt(mk(8'hFF, 8'h66), em, 1, "R5 all flags");
    endtask

    task automatic t_stall;
        logic [L*W-1:0] d;
        d = mk(8'h01, 8'h77);
        @(negedge clk);
        fp_valid = 1'b1; fp_data = d;
        @(posedge clk); @(negedge clk);
        fp_valid = 1'b0; ep_stall = 1'b1;
        for (int c = 0; c < 3; c++) begin
            #1;
            chk(ep_valid === 1'b1 && ep_mask === 8'h03 && ep_data === gate(d, 8'h03) && ep_last === 1'b0,
                "R7 stall hold", 256'(ep_mask), 256'(8'h03));
            chk(fp_ready === 1'b0, "R8 busy not ready", 256'(fp_ready), 256'(0));
            @(posedge clk); @(negedge clk);
        end
        ep_stall = 1'b0;
        #1 chk(ep_mask === 8'h03, "R7 release", 256'(ep_mask), 256'(8'h03));
        @(posedge clk); @(negedge clk);
        #1 chk(ep_mask === 8'h04, "R9 after stall", 256'(ep_mask), 256'(8'h04));
        for (int k = 0; k < 6; k++) begin @(posedge clk); @(negedge clk); end
        #1 chk(ep_valid === 1'b0, "R9 stall drained", 256'(ep_valid), 256'(0));
    endtask

    task automatic t_back2back;
        logic [L*W-1:0] a, b;
        a = mk(8'h7F, 8'h88);
        b = mk(8'h0F, 8'h99);
        @(negedge clk);
        fp_valid = 1'b1; fp_data = a; ep_stall = 1'b1;
        @(posedge clk); @(negedge clk);
        fp_data = b;
        #1 chk(fp_ready === 1'b0, "R8 stalled last blocks", 256'(fp_ready), 256'(0));
        ep_stall = 1'b0;
        #1 chk(fp_ready === 1'b1 && ep_last === 1'b1, "R8 handover ready", 256'(fp_ready), 256'(1));
        @(posedge clk); @(negedge clk);
        fp_valid = 1'b0;
        #1 chk(ep_valid === 1'b1 && ep_mask === 8'h1F && ep_data === gate(b, 8'h1F),
               "R8 next packet at once", 256'(ep_mask), 256'(8'h1F));
        for (int k = 0; k < 4; k++) begin @(posedge clk); @(negedge clk); end
        #1 chk(ep_valid === 1'b0, "R10 second drained", 256'(ep_valid), 256'(0));
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #35 t_reset();
        rst_n = 1'b1;
        t_serial();
        t_parallel();
        t_mixed();
        t_top_flag();
        t_stall();
        t_back2back();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule